// File: doc/BRIEF.md
# 64b/66b Receive Block Decoder with Sequence-Violation Back-Marking

This block sits after block alignment and descrambling in a 10G-class receive path. Each clock it may accept one 66-bit block. The block is a 2-bit sync prefix plus a 64-bit payload. The decoder sorts each block into one of five classes: data, start, terminate, idle-control or invalid. It then expands the block into eight octet lanes, each lane with its own control flag. Lane i of the payload is bits 8i+7..8i, and lane 0 carries the block type byte of a control block.

Each decoded block waits one extra stage before it is released. A small receive state machine tracks whether a packet is open. Suppose the block that follows breaks the allowed order of block types. The held block is then replaced with error characters, together with the offending block. A corrupted prefix can make a data block look like an early terminate. The next terminate then arrives with no packet open, and the back-marking turns the false end of packet into an error. A saturating counter of bad-prefix blocks gives a rough measure of link health.

Top module: `b66_rx_decode`

## Requirements
- R1: Timing and idle fill.
  - `outValid` follows `inValid` exactly two clock edges later.
  - While `outValid` is low, every lane carries 0x07 and `outCtrl` is 8'hFF.
- R2: A block with prefix 2'b01 is data. Payload lane i appears on output lane i, and `outCtrl` is 0.
- R3: A prefix 2'b10 block with type byte 0x1E is output as 0x07 on all eight lanes, with `outCtrl` 8'hFF.
- R4: A prefix 2'b10 block with type byte 0x78 is a start block.
  - Lane 0 is output as 0xFB with `outCtrl` bit 0 set.
  - Payload lanes 1..7 pass through as data on output lanes 1..7.
- R5: Prefix 2'b10 blocks with type 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF are terminates, with the terminate in lane k = 0..7 respectively.
  - Output lanes 0..k-1 carry payload lanes 1..k as data.
  - Lane k is 0xFD.
  - Lanes above k are 0x07.
  - `outCtrl` bits k..7 are set and the bits below k are clear.
- R6: An invalid block is output as 0xFE on every lane, with `outCtrl` 8'hFF. A block is invalid if its prefix is 2'b00 or 2'b11, or if its prefix is 2'b10 and its type byte is not listed in R3 to R5.
- R7: Sequence rules. The receiver is either idle or inside a packet, and it starts idle.
  - A start block is legal only when idle. Data and terminate blocks are legal only inside a packet. Idle-control blocks are legal only when idle.
  - An illegal block is output as in R6.
  - After a block, the receiver is inside a packet if the block was a start. It is idle if the block was a terminate, an idle-control block or an invalid block. After a data block the state is unchanged.
- R8: Back-marking.
  - A valid, legal-class block can break R7 on the cycle right after another accepted block. The earlier block is then also output as in R6.
  - After a gap of one or more cycles, the earlier block is left as decoded.
  - An invalid block never back-marks.
- R9: `errCount` counts accepted blocks with prefix 2'b00 or 2'b11. It rises one edge after such a block and saturates at all ones.
- R10: `clrCount` high at an edge sets `errCount` to zero at that edge, even if a bad-prefix block is accepted at the same edge.
- R11: Synchronous reset does four things.
  - The receiver returns to idle.
  - `errCount` is cleared.
  - `outValid` goes low.
  - The outputs show the R1 idle fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A block is present on this cycle |
| inHeader | input | 2 | Sync prefix (2'b01 data, 2'b10 control) |
| inPayload | input | 64 | Block payload, lane 0 in bits 7..0 |
| clrCount | input | 1 | Clears the bad-prefix counter |
| outValid | output | 1 | Decoded block present on the outputs |
| outData | output | 64 | Eight decoded octets, lane 0 in bits 7..0 |
| outCtrl | output | 8 | Control flag for each lane |
| errCount | output | CNT_W | Saturating count of bad-prefix blocks |

## Verification
The bound checker watches five things on every cycle:
- the two-edge valid latency;
- the idle fill whenever no block is released;
- the all-error output for a bad prefix;
- the counter stepping by at most one, saturating and clearing;
- the state right after reset.

Decoding of each block class, the packet state sequence and back-marking all depend on the blocks that came before. They are shown only by the bench's scenarios, which include:
- terminates in every lane;
- a data block corrupted into a false terminate;
- data arriving while idle;
- repeated starts with and without a gap;
- a reset in the middle of a packet.

// File: rtl/b66_pkg.sv
package b66_pkg;
  localparam int LANES = 8;
  localparam int OCT   = 8;
  localparam int DW    = LANES * OCT;

  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_ERR   = 8'hFE;

  localparam logic [7:0] TY_IDLE  = 8'h1E;
  localparam logic [7:0] TY_START = 8'h78;

  localparam logic [1:0] HDR_DATA = 2'b01;
  localparam logic [1:0] HDR_CTRL = 2'b10;

  typedef enum logic [2:0] {
    BLK_DATA,
    BLK_START,
    BLK_TERM,
    BLK_IDLE,
    BLK_BAD
  } blkClass_e;

  typedef enum logic {
    ST_IDLE,
    ST_PKT
  } rxState_e;

  // Strobes from the sequence controller to the datapath.
  typedef struct packed {
    logic capErr;    // block being captured is itself errored
    logic backMark;  // held block must be released as errors
  } ctlStrobe_t;

  // Type byte of the terminate block whose terminate sits in lane k.
  function automatic logic [7:0] termCode(input int k);
    case (k)
      0:       termCode = 8'h87;
      1:       termCode = 8'h99;
      2:       termCode = 8'hAA;
      3:       termCode = 8'hB4;
      4:       termCode = 8'hCC;
      5:       termCode = 8'hD2;
      6:       termCode = 8'hE1;
      default: termCode = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/b66_blk_decode.sv
module b66_blk_decode
  import b66_pkg::*;
(
  input  logic [1:0]       hdr,
  input  logic [DW-1:0]    payload,
  output blkClass_e        cls,
  output logic             hdrBad,
  output logic [DW-1:0]    decData,
  output logic [LANES-1:0] decCtrl
);
  logic [7:0]                 typeByte;
  logic [LANES-1:0]           termHit;
  logic [LANES-1:0][OCT-1:0]  termDat [LANES];
  logic [LANES-1:0]           termCtr [LANES];
  logic [DW-1:0]              termSel;
  logic [LANES-1:0]           termCtrSel;

  assign typeByte = payload[7:0];

  // One candidate output for each terminate position.
  for (genvar k = 0; k < LANES; k++) begin : g_term
    assign termHit[k] = (typeByte == termCode(k));
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i < k) begin : g_dat
        assign termDat[k][i] = payload[OCT*(i+1) +: OCT];
      end else if (i == k) begin : g_end
        assign termDat[k][i] = CH_TERM;
      end else begin : g_pad
        assign termDat[k][i] = CH_IDLE;
      end
      assign termCtr[k][i] = (i >= k);
    end
  end

  // The type codes are distinct, so at most one candidate is selected.
  always_comb begin
    termSel    = '0;
    termCtrSel = '0;
    for (int k = 0; k < LANES; k++) begin
      if (termHit[k]) begin
        termSel    = termSel | termDat[k];
        termCtrSel = termCtrSel | termCtr[k];
      end
    end
  end

  always_comb begin
    hdrBad  = (hdr == 2'b00) || (hdr == 2'b11);
    cls     = BLK_BAD;
    decData = {LANES{CH_ERR}};
    decCtrl = '1;
    if (hdrBad) begin
      cls = BLK_BAD;
    end else if (hdr == HDR_DATA) begin
      cls     = BLK_DATA;
      decData = payload;
      decCtrl = '0;
    end else if (typeByte == TY_IDLE) begin
      cls     = BLK_IDLE;
      decData = {LANES{CH_IDLE}};
      decCtrl = '1;
    end else if (typeByte == TY_START) begin
      cls     = BLK_START;
      decData = {payload[DW-1:OCT], CH_START};
      decCtrl = {{(LANES-1){1'b0}}, 1'b1};
    end else if (|termHit) begin
      cls     = BLK_TERM;
      decData = termSel;
      decCtrl = termCtrSel;
    end
  end
endmodule

// File: rtl/b66_dp.sv
module b66_dp
  import b66_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [1:0]       inHeader,
  input  logic [DW-1:0]    inPayload,
  input  ctlStrobe_t       ctl,
  output blkClass_e        blkClass,
  output logic             hdrBad,
  output logic             outValid,
  output logic [DW-1:0]    outData,
  output logic [LANES-1:0] outCtrl
);
  localparam logic [DW-1:0] IDLE_WORD = {LANES{CH_IDLE}};
  localparam logic [DW-1:0] ERR_WORD  = {LANES{CH_ERR}};

  logic [DW-1:0]    decData;
  logic [LANES-1:0] decCtrl;
  logic             s1Valid;
  logic             s1Err;
  logic [DW-1:0]    s1Data;
  logic [LANES-1:0] s1Ctrl;

  b66_blk_decode u_dec (
    .hdr     (inHeader),
    .payload (inPayload),
    .cls     (blkClass),
    .hdrBad  (hdrBad),
    .decData (decData),
    .decCtrl (decCtrl)
  );

  // Hold stage: keeps the decoded block while the next one is judged.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s1Err   <= 1'b0;
      s1Data  <= IDLE_WORD;
      s1Ctrl  <= '1;
    end else begin
      s1Valid <= inValid;
      if (inValid) begin
        s1Err  <= ctl.capErr;
        s1Data <= decData;
        s1Ctrl <= decCtrl;
      end
    end
  end

  // Release stage: back-marking is applied as the block leaves.
  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= IDLE_WORD;
      outCtrl  <= '1;
    end else begin
      outValid <= s1Valid;
      if (!s1Valid) begin
        outData <= IDLE_WORD;
        outCtrl <= '1;
      end else if (s1Err || ctl.backMark) begin
        outData <= ERR_WORD;
        outCtrl <= '1;
      end else begin
        outData <= s1Data;
        outCtrl <= s1Ctrl;
      end
    end
  end
endmodule

// File: rtl/b66_seq_ctrl.sv
module b66_seq_ctrl
  import b66_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  blkClass_e        blkClass,
  input  logic             hdrBad,
  input  logic             clrCount,
  output ctlStrobe_t       ctl,
  output logic [CNT_W-1:0] errCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  rxState_e state, stateNxt;
  logic     legal;

  always_comb begin
    unique case (blkClass)
      BLK_START: legal = (state == ST_IDLE);
      BLK_IDLE:  legal = (state == ST_IDLE);
      BLK_DATA:  legal = (state == ST_PKT);
      BLK_TERM:  legal = (state == ST_PKT);
      default:   legal = 1'b0;
    endcase
  end

  always_comb begin
    stateNxt = state;
    if (inValid) begin
      unique case (blkClass)
        BLK_START: stateNxt = ST_PKT;
        BLK_DATA:  stateNxt = state;
        default:   stateNxt = ST_IDLE;
      endcase
    end
  end

  assign ctl.capErr   = (blkClass == BLK_BAD) || !legal;
  assign ctl.backMark = inValid && (blkClass != BLK_BAD) && !legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clrCount) begin
      errCount <= '0;
    end else if (inValid && hdrBad && (errCount != CNT_MAX)) begin
      errCount <= errCount + 1'b1;
    end
  end
endmodule

// File: rtl/b66_rx_decode.sv
module b66_rx_decode
  import b66_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [1:0]       inHeader,
  input  logic [DW-1:0]    inPayload,
  input  logic             clrCount,
  output logic             outValid,
  output logic [DW-1:0]    outData,
  output logic [LANES-1:0] outCtrl,
  output logic [CNT_W-1:0] errCount
);
  ctlStrobe_t ctl;
  blkClass_e  blkClass;
  logic       hdrBad;

  b66_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inHeader  (inHeader),
    .inPayload (inPayload),
    .ctl       (ctl),
    .blkClass  (blkClass),
    .hdrBad    (hdrBad),
    .outValid  (outValid),
    .outData   (outData),
    .outCtrl   (outCtrl)
  );

  b66_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .blkClass (blkClass),
    .hdrBad   (hdrBad),
    .clrCount (clrCount),
    .ctl      (ctl),
    .errCount (errCount)
  );
endmodule

// File: rtl/b66_rx_checker.sv
module b66_rx_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [1:0]       inHeader,
  input logic             clrCount,
  input logic             outValid,
  input logic [63:0]      outData,
  input logic [7:0]       outCtrl,
  input logic [CNT_W-1:0] errCount
);
  logic [1:0]       sinceRst;
  logic [CNT_W-1:0] cntPrev;
  logic [CNT_W-1:0] cntDelta;
  logic             clrPrev;
  logic             badPrefix;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= 2'd0;
    end else if (sinceRst != 2'd3) begin
      sinceRst <= sinceRst + 2'd1;
    end
    cntPrev <= errCount;
    clrPrev <= clrCount;
  end

  assign cntDelta  = errCount - cntPrev;
  assign badPrefix = inValid && ((inHeader == 2'b00) || (inHeader == 2'b11));

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2) |-> (outValid == $past(inValid, 2)));

  p_idle_fill_r1: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (outData == {8{8'h07}} && outCtrl == 8'hFF));

  p_bad_prefix_r6: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && $past(badPrefix, 2)) |-> (outData == {8{8'hFE}} && outCtrl == 8'hFF));

  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 2'd0 && !clrPrev) |-> (cntDelta <= CNT_W'(1)));

  p_count_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (!clrCount && errCount == {CNT_W{1'b1}}) |=> (errCount == {CNT_W{1'b1}}));

  p_count_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clrCount |=> (errCount == '0));

  p_reset_state_r11: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd0) |-> (errCount == '0 && !outValid && outCtrl == 8'hFF));
endmodule

bind b66_rx_decode b66_rx_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inHeader (inHeader),
  .clrCount (clrCount),
  .outValid (outValid),
  .outData  (outData),
  .outCtrl  (outCtrl),
  .errCount (errCount)
);

// File: tb/test_b66_rx_decode.sv
module test_b66_rx_decode;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [1:0]    inHeader = 2'b01;
  logic [63:0]   inPayload = '0;
  logic          clrCount = 1'b0;
  logic          outValid;
  logic [63:0]   outData;
  logic [7:0]    outCtrl;
  logic [CW-1:0] errCount;

  b66_rx_decode #(.CNT_W(CW)) i_b66_rx_decode (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inHeader  (inHeader),
    .inPayload (inPayload),
    .clrCount  (clrCount),
    .outValid  (outValid),
    .outData   (outData),
    .outCtrl   (outCtrl),
    .errCount  (errCount)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [63:0] d;
    logic [7:0]  c;
    int          due;
    string       tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    nChecks = 0;
  int    nErrors = 0;
  bit    done = 1'b0;
  bit    prevSent = 1'b0;
  int    refState = 0;
  int    refCnt = 0;

  localparam logic [7:0] TCODE [8] = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input logic [71:0] act, input logic [71:0] expv);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  // Class codes: 0 data, 1 start, 2 terminate, 3 idle-control, 4 invalid.
  function automatic void refDecode(input logic [1:0] h, input logic [63:0] p,
                                    output int cls, output logic [63:0] d, output logic [7:0] c);
    cls = 4;
    d   = {8{8'hFE}};
    c   = 8'hFF;
    if (h == 2'b01) begin
      cls = 0; d = p; c = 8'h00;
    end else if (h == 2'b10) begin
      if (p[7:0] == 8'h1E) begin
        cls = 3; d = {8{8'h07}}; c = 8'hFF;
      end else if (p[7:0] == 8'h78) begin
        cls = 1; d = {p[63:8], 8'hFB}; c = 8'h01;
      end else begin
        for (int k = 0; k < 8; k++) begin
          if (p[7:0] == TCODE[k]) begin
            cls = 2;
            for (int i = 0; i < 8; i++) begin
              if (i < k)       d[8*i +: 8] = p[8*i+8 +: 8];
              else if (i == k) d[8*i +: 8] = 8'hFD;
              else             d[8*i +: 8] = 8'h07;
              c[i] = (i >= k);
            end
          end
        end
      end
    end
  endfunction

  // Driver: presents one block and pushes its expected output.
  task automatic sendBlk(input logic [1:0] h, input logic [63:0] p, input string tag);
    int          cls;
    logic [63:0] d;
    logic [7:0]  c;
    bit          legal;
    exp_t        e;
    @(negedge clk);
    inValid   = 1'b1;
    inHeader  = h;
    inPayload = p;
    refDecode(h, p, cls, d, c);
    case (cls)
      0, 2:    legal = (refState == 1);
      1, 3:    legal = (refState == 0);
      default: legal = 1'b0;
    endcase
    if (cls != 4 && !legal && prevSent && q.size() > 0) begin
      e = q[q.size()-1];
      e.d = {8{8'hFE}};
      e.c = 8'hFF;
      e.tag = "R8 back-marked";
      q[q.size()-1] = e;
    end
    e.d   = legal ? d : {8{8'hFE}};
    e.c   = legal ? c : 8'hFF;
    e.due = cyc + 2;
    e.tag = tag;
    q.push_back(e);
    if (cls == 1)      refState = 1;
    else if (cls != 0) refState = 0;
    if ((h == 2'b00 || h == 2'b11) && refCnt < (1 << CW) - 1) refCnt++;
    prevSent = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      inValid  = 1'b0;
      prevSent = 1'b0;
    end
  endtask

  function automatic logic [63:0] ctlBlk(input logic [7:0] ty, input logic [55:0] rest);
    return {rest, ty};
  endfunction

  // Monitor: compares released blocks against the scoreboard.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (rst) continue;
      if (outValid) begin
        if (q.size() == 0) begin
          check(1'b0, "R1 output with nothing expected", {outCtrl, outData}, '0);
        end else begin
          e = q.pop_front();
          check(outData == e.d && outCtrl == e.c, e.tag, {outCtrl, outData}, {e.c, e.d});
          check(cyc == e.due, "R1 latency", 72'(cyc), 72'(e.due));
        end
      end else begin
        check(outData == {8{8'h07}} && outCtrl == 8'hFF, "R1 idle fill",
              {outCtrl, outData}, {8'hFF, {8{8'h07}}});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && outData == {8{8'h07}} && outCtrl == 8'hFF && errCount == 0,
          "R11 reset state", {outCtrl, outData}, {8'hFF, {8{8'h07}}});
    rst = 1'b0;

    // R3 R4 R2 R5: one well formed packet
    sendBlk(2'b10, ctlBlk(8'h1E, '0), "R3 idle block");
    sendBlk(2'b10, ctlBlk(8'h78, 56'h11223344556677), "R4 start");
    sendBlk(2'b01, 64'h0123456789ABCDEF, "R2 data");
    sendBlk(2'b01, 64'hFEDCBA9876543210, "R2 data");
    sendBlk(2'b10, ctlBlk(8'hB4, 56'hA1A2A3A4A5A6A7), "R5 term lane3");
    // R5: terminate in every lane
    for (int k = 0; k < 8; k++) begin
      sendBlk(2'b10, ctlBlk(8'h78, 56'hC0C1C2C3C4C5C6), "R4 start");
      sendBlk(2'b01, {8{8'(k + 8'h30)}}, "R2 data");
      sendBlk(2'b10, ctlBlk(TCODE[k], 56'h0F1E2D3C4B5A69), $sformatf("R5 term lane%0d", k));
    end
    sendBlk(2'b10, ctlBlk(8'h1E, '0), "R3 idle block");
    idle(2);

    // R7 R8: data while idle marks itself and the idle block before it
    sendBlk(2'b10, ctlBlk(8'h1E, '0), "R3 idle block");
    sendBlk(2'b01, 64'h5555AAAA5555AAAA, "R7 data while idle");
    idle(1);

    // R8: a data block corrupted into a false terminate
    sendBlk(2'b10, ctlBlk(8'h78, 56'h01010101010101), "R4 start");
    sendBlk(2'b10, ctlBlk(8'h87, 56'h02020202020202), "R5 false term");
    sendBlk(2'b10, ctlBlk(8'h99, 56'h03030303030303), "R7 term while idle");
    sendBlk(2'b10, ctlBlk(8'h1E, '0), "R3 idle after recovery");
    idle(1);

    // R8: a gap before the offending block protects the earlier one
    sendBlk(2'b10, ctlBlk(8'h78, 56'h10101010101010), "R4 start before gap");
    idle(2);
    sendBlk(2'b10, ctlBlk(8'h78, 56'h20202020202020), "R8 start after gap");
    sendBlk(2'b10, ctlBlk(8'hFF, 56'h30303030303030), "R5 term lane7");
    idle(1);

    // R6: bad prefixes and an unknown type; invalid blocks do not back-mark
    sendBlk(2'b10, ctlBlk(8'h78, 56'h40404040404040), "R4 start");
    sendBlk(2'b01, 64'h1111111111111111, "R2 data");
    sendBlk(2'b11, 64'h2222222222222222, "R6 prefix 11");
    sendBlk(2'b01, 64'h3333333333333333, "R7 data after invalid");
    sendBlk(2'b10, ctlBlk(8'h55, '0), "R6 unknown type");
    sendBlk(2'b00, 64'h4444444444444444, "R6 prefix 00");
    idle(1);
    check(errCount == CW'(refCnt), "R9 count two bad prefixes", 72'(errCount), 72'(refCnt));

    // R9: saturation
    for (int j = 0; j < 9; j++) sendBlk(2'b00, 64'(j), "R6 prefix 00");
    idle(1);
    check(errCount == 3'd7 && refCnt == 7, "R9 saturates", 72'(errCount), 72'd7);

    // R10: clear alone, then clear together with a bad prefix
    @(negedge clk); clrCount = 1'b1;
    @(negedge clk); clrCount = 1'b0;
    check(errCount == 0, "R10 clear", 72'(errCount), 72'd0);
    refCnt = 0;
    sendBlk(2'b11, 64'h0, "R6 prefix 11");
    clrCount = 1'b1;
    idle(1);
    clrCount = 1'b0;
    refCnt = 0;
    check(errCount == 0, "R10 clear wins over count", 72'(errCount), 72'd0);
    sendBlk(2'b11, 64'h0, "R6 prefix 11");
    idle(1);
    check(errCount == 1, "R9 count after clear", 72'(errCount), 72'd1);

    // R11: reset inside a packet returns to idle
    sendBlk(2'b10, ctlBlk(8'h78, 56'h50505050505050), "R4 start");
    idle(4);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!outValid && outCtrl == 8'hFF && errCount == 0, "R11 reset mid packet",
          {7'd0, outValid, outCtrl, 56'(errCount)}, {8'h0, 8'hFF, 56'h0});
    rst = 1'b0;
    refState = 0;
    refCnt = 0;
    prevSent = 1'b0;
    sendBlk(2'b10, ctlBlk(8'h78, 56'h60606060606060), "R11 start legal after reset");
    sendBlk(2'b10, ctlBlk(8'hAA, 56'h70707070707070), "R5 term lane2");
    idle(5);
    check(q.size() == 0, "R1 all expected blocks released", 72'(q.size()), 72'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule